// File: doc/BRIEF.md
# Host I/O Cycle Destination Decoder

This block sits on the host side of a bridge. It receives processor I/O cycles, each with a start address, a byte length and a read/write flag, and sends each one to exactly one place. The three places are a register inside the bridge, the graphics-port bus, and the PCI bus. Three register locations are claimed locally: the configuration address register, the configuration data window and a power-management control byte. A programmable base/limit window steers cycles to the graphics-port bus. Every other cycle falls through to PCI. The start address goes out unchanged.

The block also produces a seventeenth address bit. This bit is set when a multi-byte access runs past the top of the 64K I/O space, which makes 64K+3 byte locations reachable. Writes into the disk-controller (IDE) I/O range are not posted. The request port deasserts its ready signal until the downstream side reports that the cycle has completed.

Top module: `hio_route_top`

## Requirements
- R1: After reset, `dst_vld` is 0, `req_rdy` is 1 and the graphics window is closed (base FFFFh, limit 0000h), so any cycle goes to PCI.
- R2: A request accepted while `req_vld` and `req_rdy` are both high yields `dst_vld` = 1 on the next cycle. At that point `dst_sel` has exactly one bit set: bit 2 internal, bit 1 graphics-port bus, bit 0 PCI.
- R3: A 4-byte access (length code 2 or 3) at 0CF8h goes internal. A write there loads the config-enable flag from `req_wdata_b31`. Any other length at 0CF8h is not claimed.
- R4: An access of any length starting at 0CFCh–0CFFh goes internal only while the config-enable flag is 1. Otherwise it is decoded like any other address.
- R5: A 1-byte access (length code 0) at the power-management address (default 0022h) goes internal.
- R6: When base <= address <= limit, inclusive at both ends, the cycle goes to the graphics-port bus. The window registers are written through `win_we`, where `win_sel` 0 selects base and 1 selects limit.
- R7: While base > limit, no cycle goes to the graphics-port bus.
- R8: An internal register hit wins over a window hit, and a window hit wins over the PCI default.
- R9: `dst_addr`, `dst_len` and `dst_wr` equal the accepted request's address, length and direction.
- R10: `dst_a16` is 1 for a 4-byte access starting at FFFDh, FFFEh or FFFFh, and for a 2-byte access (length code 1) starting at FFFFh. It is 0 for every other access.
- R11: A write starting in the IDE range (default 01F0h–01F7h) sets `dst_nonpost`. `req_rdy` drops on the next cycle and stays low until the cycle after `dn_done` is seen. Requests offered while `req_rdy` is low are not accepted and produce no `dst_vld`.
- R12: Reads in the IDE range, and writes outside it, leave `dst_nonpost` at 0 and `req_rdy` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | I/O cycle request strobe |
| req_addr | input | 16 | Start address of the I/O cycle |
| req_len | input | 2 | Length code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata_b31 | input | 1 | Bit 31 of the write data |
| req_rdy | output | 1 | Request may be accepted |
| win_we | input | 1 | Window register write strobe |
| win_sel | input | 1 | 0 = base, 1 = limit |
| win_data | input | 16 | Window register write value |
| dn_done | input | 1 | Downstream completion of a non-posted write |
| dst_vld | output | 1 | Routed cycle valid |
| dst_sel | output | 3 | One-hot destination {internal, graphics port, PCI} |
| dst_addr | output | 16 | Forwarded address |
| dst_a16 | output | 1 | Wrap-around carry address bit |
| dst_len | output | 2 | Forwarded length code |
| dst_wr | output | 1 | Forwarded direction |
| dst_nonpost | output | 1 | Cycle must not be posted |

## Verification
The window is tested at each edge and one step outside it, so an off-by-one in either comparison is caught. It is also tested with base above limit, which catches a missing enable. The configuration window is tried both before and after the enable bit is written, and 0CF8h is tried with a 1-byte length, which separates the flag logic from the plain address match. Priority is checked with a window that covers the whole space. The wrap bit is probed on both sides of each boundary for each length. The write handshake is driven with a blocked request and a delayed completion, then compared against an IDE read and a write just outside the range.

// File: rtl/hio_pkg.sv
package hio_pkg;

    localparam int IO_AW = 16;

    typedef enum logic [1:0] {
        LEN_B1  = 2'd0,
        LEN_B2  = 2'd1,
        LEN_B4  = 2'd2,
        LEN_B4X = 2'd3
    } io_len_e;

    typedef struct packed {
        logic intl;
        logic agp;
        logic pci;
    } dst_t;

    typedef struct packed {
        logic [IO_AW-1:0] addr;
        io_len_e          len;
        logic             wr;
    } io_req_t;

    function automatic logic is_quad(input io_len_e len);
        return len[1];
    endfunction

    // carry into bit 16 when the last byte lands beyond FFFFh
    function automatic logic wrap_carry(input logic [IO_AW-1:0] addr, input io_len_e len);
        logic [IO_AW:0] last;
        logic [2:0]     span;
        span = is_quad(len) ? 3'd3 : (len == LEN_B2 ? 3'd1 : 3'd0);
        last = {1'b0, addr} + {{(IO_AW-2){1'b0}}, span};
        return last[IO_AW];
    endfunction

    function automatic dst_t pick_dst(input logic local_hit, input logic agp_hit);
        dst_t d;
        d = '0;
        if (local_hit)    d.intl = 1'b1;
        else if (agp_hit) d.agp  = 1'b1;
        else              d.pci  = 1'b1;
        return d;
    endfunction

endpackage

// File: rtl/hio_win_regs.sv
module hio_win_regs
    import hio_pkg::*;
#(
    parameter int AW = IO_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          win_we,
    input  logic          win_sel,
    input  logic [AW-1:0] win_data,
    input  logic [AW-1:0] chk_addr,
    output logic          agp_hit
);

    logic [AW-1:0] base_q;
    logic [AW-1:0] limit_q;
    logic          win_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '1;
            limit_q <= '0;
        end else if (win_we) begin
            if (win_sel) limit_q <= win_data;
            else         base_q  <= win_data;
        end
    end

    assign win_open = (base_q <= limit_q);
    assign agp_hit  = win_open && (chk_addr >= base_q) && (chk_addr <= limit_q);

    AST_WIN_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (base_q > limit_q) |-> !agp_hit); // R7

    AST_WIN_RESET: assert property (@(posedge clk)
        $fell(rst) |-> (base_q > limit_q)); // R1

endmodule

// File: rtl/hio_local_regs.sv
module hio_local_regs
    import hio_pkg::*;
#(
    parameter int          AW       = IO_AW,
    parameter logic [15:0] CFG_ADDR = 16'h0CF8,
    parameter logic [15:0] CFG_DATA = 16'h0CFC,
    parameter logic [15:0] PM_ADDR  = 16'h0022
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    acc,
    input  io_req_t req,
    input  logic    wd_b31,
    output logic    local_hit
);

    logic cfg_en_q;
    logic hit_cfg_addr;
    logic hit_cfg_data;
    logic hit_pm;

    assign hit_cfg_addr = (req.addr == CFG_ADDR[AW-1:0]) && is_quad(req.len);
    assign hit_cfg_data = (req.addr[AW-1:2] == CFG_DATA[AW-1:2]) && cfg_en_q;
    assign hit_pm       = (req.addr == PM_ADDR[AW-1:0]) && (req.len == LEN_B1);
    assign local_hit    = hit_cfg_addr || hit_cfg_data || hit_pm;

    always_ff @(posedge clk) begin
        if (rst)                           cfg_en_q <= 1'b0;
        else if (acc && req.wr && hit_cfg_addr) cfg_en_q <= wd_b31;
    end

    AST_CFG_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(acc && req.wr && hit_cfg_addr) |=> $stable(cfg_en_q)); // R3

    AST_CFG_DATA_GATE: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en_q && req.addr[AW-1:2] == CFG_DATA[AW-1:2]) |-> !hit_cfg_data); // R4

endmodule

// File: rtl/hio_np_ctrl.sv
module hio_np_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic acc,
    input  logic np_write,
    input  logic dn_done,
    output logic rdy
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)                 pend_q <= 1'b0;
        else if (acc && np_write) pend_q <= 1'b1;
        else if (dn_done)        pend_q <= 1'b0;
    end

    assign rdy = !pend_q;

    AST_NP_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (acc && np_write) |=> !rdy); // R11

    AST_NP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!rdy && dn_done) |=> rdy); // R11

endmodule

// File: rtl/hio_route_top.sv
module hio_route_top
    import hio_pkg::*;
#(
    parameter int          AW       = IO_AW,
    parameter logic [15:0] CFG_ADDR = 16'h0CF8,
    parameter logic [15:0] CFG_DATA = 16'h0CFC,
    parameter logic [15:0] PM_ADDR  = 16'h0022,
    parameter logic [15:0] IDE_LO   = 16'h01F0,
    parameter logic [15:0] IDE_HI   = 16'h01F7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_vld,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_len,
    input  logic          req_wr,
    input  logic          req_wdata_b31,
    output logic          req_rdy,
    input  logic          win_we,
    input  logic          win_sel,
    input  logic [AW-1:0] win_data,
    input  logic          dn_done,
    output logic          dst_vld,
    output logic [2:0]    dst_sel,
    output logic [AW-1:0] dst_addr,
    output logic          dst_a16,
    output logic [1:0]    dst_len,
    output logic          dst_wr,
    output logic          dst_nonpost
);

    io_req_t req;
    logic    acc;
    logic    local_hit;
    logic    agp_hit;
    logic    ide_hit;
    logic    np_write;
    dst_t    dst_d;

    dst_t          dst_q;
    logic          vld_q;
    logic [AW-1:0] addr_q;
    logic          a16_q;
    io_len_e       len_q;
    logic          wr_q;
    logic          np_q;

    assign req.addr = req_addr;
    assign req.len  = io_len_e'(req_len);
    assign req.wr   = req_wr;

    assign acc      = req_vld && req_rdy;
    assign ide_hit  = (req_addr >= IDE_LO[AW-1:0]) && (req_addr <= IDE_HI[AW-1:0]);
    assign np_write = req_wr && ide_hit;
    assign dst_d    = pick_dst(local_hit, agp_hit);

    hio_win_regs #(.AW(AW)) u_win (
        .clk      (clk),
        .rst      (rst),
        .win_we   (win_we),
        .win_sel  (win_sel),
        .win_data (win_data),
        .chk_addr (req_addr),
        .agp_hit  (agp_hit)
    );

    hio_local_regs #(
        .AW       (AW),
        .CFG_ADDR (CFG_ADDR),
        .CFG_DATA (CFG_DATA),
        .PM_ADDR  (PM_ADDR)
    ) u_loc (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .req       (req),
        .wd_b31    (req_wdata_b31),
        .local_hit (local_hit)
    );

    hio_np_ctrl u_np (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .np_write (np_write),
        .dn_done  (dn_done),
        .rdy      (req_rdy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            dst_q  <= '0;
            addr_q <= '0;
            a16_q  <= 1'b0;
            len_q  <= LEN_B1;
            wr_q   <= 1'b0;
            np_q   <= 1'b0;
        end else begin
            vld_q <= acc;
            if (acc) begin
                dst_q  <= dst_d;
                addr_q <= req.addr;
                a16_q  <= wrap_carry(req.addr, req.len);
                len_q  <= req.len;
                wr_q   <= req.wr;
                np_q   <= np_write;
            end
        end
    end

    assign dst_vld     = vld_q;
    assign dst_sel     = vld_q ? dst_q : 3'b000;
    assign dst_addr    = addr_q;
    assign dst_a16     = vld_q && a16_q;
    assign dst_len     = len_q;
    assign dst_wr      = wr_q;
    assign dst_nonpost = vld_q && np_q;

    AST_DST_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        dst_vld |-> ($countones(dst_sel) == 1)); // R2

    AST_ADDR_PASS: assert property (@(posedge clk) disable iff (rst)
        dst_vld |-> (dst_addr == $past(req_addr))); // R9

    AST_A16_TOP: assert property (@(posedge clk) disable iff (rst)
        dst_a16 |-> (dst_addr >= 16'hFFFD)); // R10

    AST_BLOCKED_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_rdy |=> !dst_vld); // R11

    AST_NP_IS_WRITE: assert property (@(posedge clk) disable iff (rst)
        dst_nonpost |-> dst_wr); // R12

endmodule

// File: tb/hio_route_top_bench.sv
module hio_route_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_vld;
    logic [15:0] req_addr;
    logic [1:0]  req_len;
    logic        req_wr;
    logic        req_wdata_b31;
    logic        req_rdy;
    logic        win_we;
    logic        win_sel;
    logic [15:0] win_data;
    logic        dn_done;
    logic        dst_vld;
    logic [2:0]  dst_sel;
    logic [15:0] dst_addr;
    logic        dst_a16;
    logic [1:0]  dst_len;
    logic        dst_wr;
    logic        dst_nonpost;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [2:0] S_INT = 3'b100;
    localparam logic [2:0] S_AGP = 3'b010;
    localparam logic [2:0] S_PCI = 3'b001;

    always #2 clk = ~clk;

    hio_route_top u_hio_route_top (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_addr(req_addr),
        .req_len(req_len), .req_wr(req_wr), .req_wdata_b31(req_wdata_b31),
        .req_rdy(req_rdy), .win_we(win_we), .win_sel(win_sel),
        .win_data(win_data), .dn_done(dn_done), .dst_vld(dst_vld),
        .dst_sel(dst_sel), .dst_addr(dst_addr), .dst_a16(dst_a16),
        .dst_len(dst_len), .dst_wr(dst_wr), .dst_nonpost(dst_nonpost)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [15:0] a, input logic [1:0] l, input logic w, input logic b31);
        req_vld = 1'b1; req_addr = a; req_len = l; req_wr = w; req_wdata_b31 = b31;
        @(posedge clk); @(negedge clk);
        req_vld = 1'b0;
    endtask

    task automatic set_win(input logic [15:0] base, input logic [15:0] lim);
        win_we = 1'b1; win_sel = 1'b0; win_data = base;
        @(posedge clk); @(negedge clk);
        win_sel = 1'b1; win_data = lim;
        @(posedge clk); @(negedge clk);
        win_we = 1'b0;
    endtask

    task automatic route(input string tag, input logic [15:0] a, input logic [1:0] l,
                         input logic [2:0] exp_sel);
        issue(a, l, 1'b0, 1'b0);
        check({tag, " vld"}, {31'd0, dst_vld}, 32'd1);
        check({tag, " sel"}, {29'd0, dst_sel}, {29'd0, exp_sel});
    endtask

    task automatic t_reset();
        check("R1 vld", {31'd0, dst_vld}, 32'd0);
        check("R1 rdy", {31'd0, req_rdy}, 32'd1);
        route("R1 closed window", 16'h0000, 2'd0, S_PCI);
        route("R1 closed window top", 16'hFFFF, 2'd0, S_PCI);
    endtask

    task automatic t_window();
        set_win(16'h1000, 16'h10FF);
        route("R6 base edge", 16'h1000, 2'd0, S_AGP);
        route("R6 limit edge", 16'h10FF, 2'd1, S_AGP);
        route("R6 below", 16'h0FFF, 2'd0, S_PCI);
        route("R6 above", 16'h1100, 2'd2, S_PCI);
        issue(16'h1234, 2'd2, 1'b1, 1'b0);
        check("R9 addr", {16'd0, dst_addr}, 32'h1234);
        check("R9 len", {30'd0, dst_len}, 32'd2);
        check("R9 wr", {31'd0, dst_wr}, 32'd1);
        check("R2 one cycle", {31'd0, dst_vld}, 32'd1);
        @(negedge clk);
        check("R2 drop", {31'd0, dst_vld}, 32'd0);
    endtask

    task automatic t_closed();
        set_win(16'h2000, 16'h1FFF);
        route("R7 at base", 16'h2000, 2'd0, S_PCI);
        route("R7 at limit", 16'h1FFF, 2'd0, S_PCI);
        set_win(16'h3000, 16'h3000);
        route("R6 single", 16'h3000, 2'd0, S_AGP);
    endtask

    task automatic t_cfg();
        set_win(16'h3000, 16'h3000);
        route("R4 data off", 16'h0CFC, 2'd2, S_PCI);
        route("R3 addr quad", 16'h0CF8, 2'd2, S_INT);
        route("R3 addr byte", 16'h0CF8, 2'd0, S_PCI);
        issue(16'h0CF8, 2'd2, 1'b1, 1'b1);
        check("R3 addr write", {29'd0, dst_sel}, {29'd0, S_INT});
        route("R4 data on", 16'h0CFC, 2'd2, S_INT);
        route("R4 data top", 16'h0CFF, 2'd0, S_INT);
        route("R4 data beyond", 16'h0D00, 2'd0, S_PCI);
        issue(16'h0CF8, 2'd0, 1'b1, 1'b0);
        route("R3 byte write ignored", 16'h0CFE, 2'd1, S_INT);
        issue(16'h0CF8, 2'd3, 1'b1, 1'b0);
        route("R4 data cleared", 16'h0CFC, 2'd0, S_PCI);
    endtask

    task automatic t_pm();
        route("R5 pm byte", 16'h0022, 2'd0, S_INT);
        route("R5 pm word", 16'h0022, 2'd1, S_PCI);
        route("R5 pm next", 16'h0023, 2'd0, S_PCI);
    endtask

    task automatic t_priority();
        set_win(16'h0000, 16'hFFFF);
        route("R8 pm over window", 16'h0022, 2'd0, S_INT);
        route("R8 cfg over window", 16'h0CF8, 2'd2, S_INT);
        route("R8 window over pci", 16'h0CF8, 2'd0, S_AGP);
        set_win(16'hFFFF, 16'h0000);
    endtask

    task automatic wrap(input logic [15:0] a, input logic [1:0] l, input logic exp);
        issue(a, l, 1'b0, 1'b0);
        check($sformatf("R10 a16 at %0h len %0d", a, l), {31'd0, dst_a16}, {31'd0, exp});
    endtask

    task automatic t_wrap();
        wrap(16'hFFFC, 2'd2, 1'b0);
        wrap(16'hFFFD, 2'd2, 1'b1);
        wrap(16'hFFFE, 2'd3, 1'b1);
        wrap(16'hFFFF, 2'd2, 1'b1);
        wrap(16'hFFFE, 2'd1, 1'b0);
        wrap(16'hFFFF, 2'd1, 1'b1);
        wrap(16'hFFFF, 2'd0, 1'b0);
        wrap(16'h0000, 2'd2, 1'b0);
    endtask

    task automatic t_nonpost();
        issue(16'h01F0, 2'd0, 1'b1, 1'b0);
        check("R11 nonpost", {31'd0, dst_nonpost}, 32'd1);
        check("R11 rdy low", {31'd0, req_rdy}, 32'd0);
        issue(16'h0080, 2'd0, 1'b0, 1'b0);
        check("R11 blocked no vld", {31'd0, dst_vld}, 32'd0);
        repeat (3) @(negedge clk);
        check("R11 still held", {31'd0, req_rdy}, 32'd0);
        dn_done = 1'b1;
        @(posedge clk); @(negedge clk);
        dn_done = 1'b0;
        check("R11 released", {31'd0, req_rdy}, 32'd1);
        issue(16'h01F7, 2'd1, 1'b1, 1'b0);
        check("R11 top of range", {31'd0, dst_nonpost}, 32'd1);
        dn_done = 1'b1;
        @(posedge clk); @(negedge clk);
        dn_done = 1'b0;
        issue(16'h01F0, 2'd0, 1'b0, 1'b0);
        check("R12 read posted", {31'd0, dst_nonpost}, 32'd0);
        check("R12 read rdy", {31'd0, req_rdy}, 32'd1);
        issue(16'h01F8, 2'd0, 1'b1, 1'b0);
        check("R12 outside write", {31'd0, dst_nonpost}, 32'd0);
        check("R12 outside rdy", {31'd0, req_rdy}, 32'd1);
    endtask

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_up();
    end

    initial begin
        rst = 1'b1; req_vld = 1'b0; req_addr = '0; req_len = '0; req_wr = 1'b0;
        req_wdata_b31 = 1'b0; win_we = 1'b0; win_sel = 1'b0; win_data = '0; dn_done = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_window();
        t_closed();
        t_cfg();
        t_pm();
        t_priority();
        t_wrap();
        t_nonpost();
        finish_up();
    end

endmodule